// File: doc/BRIEF.md
# AHB to Peripheral Bus Bridge

This block sits on an AHB system bus as a slave and turns each transfer it accepts into exactly one transaction on a slow peripheral bus. The peripheral bus uses a two-step handshake. A select-only cycle comes first. It is followed by one or more cycles in which select and enable are both high, and the peripheral ends the access by raising its ready line.

While the peripheral access runs, the bridge drives its ready output low, so the AHB master waits. The AHB transfer finishes only after the peripheral has finished. The bridge has no queue, so bursts are handled as a chain of single accesses, and every beat pays the full peripheral latency.

Internally, a small decoder decides whether the current address phase is for this bridge. A four-state controller (idle, setup, access, done) sequences the peripheral access. A register stage holds the address, the direction, the write data and the returned read data.

Top module: `ahb_pbus_bridge`

## Requirements
- R1: During and after an active-low reset, with no transfer yet accepted, `hreadyout` is 1, `hresp` is 0, and `pb_sel` and `pb_en` are 0.
- R2: A transfer is accepted only when `hsel`=1, `htrans` is NONSEQ (2'b10) or SEQ (2'b11), and `hready`=1 while the bridge is in idle or done. IDLE (2'b00) and BUSY (2'b01) transfers, unselected transfers and transfers with `hready`=0 start no peripheral access and see `hreadyout`=1.
- R3: In the cycle after acceptance (setup), `pb_sel`=1, `pb_en`=0, `hreadyout`=0, and `pb_addr`/`pb_wr` equal the accepted `haddr`/`hwrite`.
- R4: Write data is taken from `hwdata` in the first data-phase cycle, which is the setup cycle. It is shown on `pb_wdata` during setup and held from a register during access, whatever `hwdata` does later.
- R5: In access, `pb_sel`=1, `pb_en`=1 and `hreadyout`=0 for as long as `pb_ready` is 0. `pb_addr` and `pb_wr` stay stable from setup through the end of access.
- R6: In the cycle where `pb_ready`=1 during access, a read captures `pb_rdata`. The next cycle (done) has `hreadyout`=1 for exactly one cycle, `hrdata` equal to the captured value, and `pb_sel`=`pb_en`=0.
- R7: Each accepted transfer holds `hreadyout` low for exactly 2+W cycles, where W is the number of access cycles with `pb_ready`=0.
- R8: Each accepted AHB transfer produces exactly one peripheral transaction, in acceptance order. A transfer whose address phase falls in the done cycle is accepted there and goes straight to setup. Otherwise done returns to idle.
- R9: `hresp` is always 0 (OKAY).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Clock shared by both sides |
| hresetn | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select from the address decoder |
| htrans | input | 2 | Transfer type (IDLE/BUSY/NONSEQ/SEQ) |
| hwrite | input | 1 | 1 = write, 0 = read |
| haddr | input | ADDR_W | Transfer address |
| hwdata | input | DATA_W | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready (previous transfer done) |
| hreadyout | output | 1 | This slave's ready |
| hresp | output | 1 | Response, always OKAY (0) |
| hrdata | output | DATA_W | Read data for the completing transfer |
| pb_sel | output | 1 | Peripheral select |
| pb_en | output | 1 | Peripheral enable (access phase) |
| pb_wr | output | 1 | Peripheral direction, 1 = write |
| pb_addr | output | ADDR_W | Peripheral address |
| pb_wdata | output | DATA_W | Peripheral write data |
| pb_ready | input | 1 | Peripheral completion |
| pb_rdata | input | DATA_W | Peripheral read data |

## Verification
The bound checker checks the handshake ordering on every cycle:
- `hreadyout` must be low whenever the peripheral select is up.
- Enable may rise only after a select-only cycle.
- Enable must hold while the peripheral is not ready.
- Address and direction must stay stable across a whole access.
- Acceptance must lead to setup, and completion must lead to a one-cycle done.
- The response must always be OKAY.

Only the bench's scenarios can show the following:
- That each AHB transfer maps to the correct peripheral transaction, with the right address, direction and data, in order.
- That read data returns correctly.
- That the stall is exactly 2+W cycles for several wait counts.
- That a transfer presented during the done cycle is not lost.
- That ignored transfer types leave the peripheral bus untouched.

// File: rtl/ahb_pbus_pkg.sv
package ahb_pbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_DONE   = 2'd3
    } brg_state_e;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic RESP_OKAY = 1'b0;

    function automatic logic is_active(input logic [1:0] tr);
        return (tr == TR_NONSEQ) || (tr == TR_SEQ);
    endfunction

endpackage

// File: rtl/ahb_pbus_decode.sv
module ahb_pbus_decode
    import ahb_pbus_pkg::*;
(
    input  logic       hsel,
    input  logic [1:0] htrans,
    input  logic       hready,
    input  logic       can_take,
    output logic       accept
);

    always_comb begin
        accept = hsel && is_active(htrans) && hready && can_take;
    end

endmodule

// File: rtl/ahb_pbus_ctrl.sv
module ahb_pbus_ctrl
    import ahb_pbus_pkg::*;
(
    input  logic       hclk,
    input  logic       hresetn,
    input  logic       accept,
    input  logic       pb_ready,
    output brg_state_e state_q,
    output logic       cap_wdata,
    output logic       cap_rdata
);

    typedef struct packed {
        brg_state_e state;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        unique case (c_q.state)
            ST_IDLE:   if (accept) c_d.state = ST_SETUP;
            ST_SETUP:  c_d.state = ST_ACCESS;
            ST_ACCESS: if (pb_ready) c_d.state = ST_DONE;
            ST_DONE:   c_d.state = accept ? ST_SETUP : ST_IDLE;
            default:   c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            c_q.state <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign state_q   = c_q.state;
    assign cap_wdata = (c_q.state == ST_SETUP);
    assign cap_rdata = (c_q.state == ST_ACCESS) && pb_ready;

endmodule

// File: rtl/ahb_pbus_regs.sv
module ahb_pbus_regs #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              cap_addr,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hwrite,
    input  logic              cap_wdata,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              cap_rdata,
    input  logic [DATA_W-1:0] pb_rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cap_addr) begin
            r_d.addr = haddr;
            r_d.wr   = hwrite;
        end
        if (cap_wdata && r_q.wr) begin
            r_d.wdata = hwdata;
        end
        if (cap_rdata && !r_q.wr) begin
            r_d.rdata = pb_rdata;
        end
    end

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign addr_q  = r_q.addr;
    assign wr_q    = r_q.wr;
    assign wdata_q = r_q.wdata;
    assign rdata_q = r_q.rdata;

endmodule

// File: rtl/ahb_pbus_bridge.sv
module ahb_pbus_bridge
    import ahb_pbus_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hsel,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    output logic              hreadyout,
    output logic              hresp,
    output logic [DATA_W-1:0] hrdata,
    output logic              pb_sel,
    output logic              pb_en,
    output logic              pb_wr,
    output logic [ADDR_W-1:0] pb_addr,
    output logic [DATA_W-1:0] pb_wdata,
    input  logic              pb_ready,
    input  logic [DATA_W-1:0] pb_rdata
);

    brg_state_e        state_q;
    logic              can_take;
    logic              accept;
    logic              cap_wdata;
    logic              cap_rdata;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    assign can_take = (state_q == ST_IDLE) || (state_q == ST_DONE);

    ahb_pbus_decode u_decode (
        .hsel     (hsel),
        .htrans   (htrans),
        .hready   (hready),
        .can_take (can_take),
        .accept   (accept)
    );

    ahb_pbus_ctrl u_ctrl (
        .hclk      (hclk),
        .hresetn   (hresetn),
        .accept    (accept),
        .pb_ready  (pb_ready),
        .state_q   (state_q),
        .cap_wdata (cap_wdata),
        .cap_rdata (cap_rdata)
    );

    ahb_pbus_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .hclk      (hclk),
        .hresetn   (hresetn),
        .cap_addr  (accept),
        .haddr     (haddr),
        .hwrite    (hwrite),
        .cap_wdata (cap_wdata),
        .hwdata    (hwdata),
        .cap_rdata (cap_rdata),
        .pb_rdata  (pb_rdata),
        .addr_q    (addr_q),
        .wr_q      (wr_q),
        .wdata_q   (wdata_q),
        .rdata_q   (rdata_q)
    );

    always_comb begin
        hreadyout = can_take;
        hresp     = RESP_OKAY;
        hrdata    = rdata_q;
        pb_sel    = (state_q == ST_SETUP) || (state_q == ST_ACCESS);
        pb_en     = (state_q == ST_ACCESS);
        pb_wr     = wr_q;
        pb_addr   = addr_q;
        pb_wdata  = (state_q == ST_SETUP) ? hwdata : wdata_q;
    end

endmodule

// File: rtl/ahb_pbus_bridge_chk.sv
module ahb_pbus_bridge_chk #(
    parameter int ADDR_W = 32
) (
    input logic              hclk,
    input logic              hresetn,
    input logic              hsel,
    input logic [1:0]        htrans,
    input logic              hready,
    input logic              hreadyout,
    input logic              hresp,
    input logic              pb_sel,
    input logic              pb_en,
    input logic              pb_wr,
    input logic [ADDR_W-1:0] pb_addr,
    input logic              pb_ready
);

    // R5: master is stalled whenever the peripheral is selected
    a_r5_stall_while_sel: assert property (@(posedge hclk) disable iff (!hresetn)
        pb_sel |-> !hreadyout);

    // R3: acceptance leads to a select-only setup cycle
    a_r3_accept_to_setup: assert property (@(posedge hclk) disable iff (!hresetn)
        (hsel && htrans[1] && hready && hreadyout) |=> (pb_sel && !pb_en && !hreadyout));

    // R5: enable only rises after a setup cycle
    a_r5_enable_after_setup: assert property (@(posedge hclk) disable iff (!hresetn)
        $rose(pb_en) |-> $past(pb_sel && !pb_en));

    // R5: enable holds until the peripheral is ready
    a_r5_hold_until_ready: assert property (@(posedge hclk) disable iff (!hresetn)
        (pb_en && !pb_ready) |=> (pb_en && pb_sel));

    // R5: address and direction stable across the access
    a_r5_ctrl_stable: assert property (@(posedge hclk) disable iff (!hresetn)
        (pb_sel && $past(pb_sel)) |-> ($stable(pb_addr) && $stable(pb_wr)));

    // R6: completion gives a single ready cycle with the peripheral idle
    a_r6_done_cycle: assert property (@(posedge hclk) disable iff (!hresetn)
        (pb_en && pb_ready) |=> (hreadyout && !pb_sel && !pb_en));

    // R2: ignored transfer types never start a peripheral access
    a_r2_ignore_inactive: assert property (@(posedge hclk) disable iff (!hresetn)
        (hreadyout && !(hsel && htrans[1] && hready)) |=> !pb_sel);

    // R9: response is always OKAY
    a_r9_okay: assert property (@(posedge hclk) disable iff (!hresetn)
        hresp == 1'b0);

endmodule

bind ahb_pbus_bridge ahb_pbus_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
    .hclk      (hclk),
    .hresetn   (hresetn),
    .hsel      (hsel),
    .htrans    (htrans),
    .hready    (hready),
    .hreadyout (hreadyout),
    .hresp     (hresp),
    .pb_sel    (pb_sel),
    .pb_en     (pb_en),
    .pb_wr     (pb_wr),
    .pb_addr   (pb_addr),
    .pb_ready  (pb_ready)
);

// File: tb/ahb_pbus_bridge_bench.sv
`timescale 1ns/1ps
module ahb_pbus_bridge_bench;

    logic        hclk = 1'b0;
    logic        hresetn = 1'b0;
    logic        hsel = 1'b0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [31:0] haddr = '0;
    logic [31:0] hwdata = '0;
    logic        hready;
    logic        hready_kill = 1'b0;
    logic        hreadyout;
    logic        hresp;
    logic [31:0] hrdata;
    logic        pb_sel, pb_en, pb_wr;
    logic [31:0] pb_addr, pb_wdata;
    logic        pb_ready;
    logic [31:0] pb_rdata;

    always #2.5 hclk = ~hclk;   // 200 MHz

    assign hready = hready_kill ? 1'b0 : hreadyout;

    ahb_pbus_bridge u_ahb_pbus_bridge (
        .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .htrans(htrans),
        .hwrite(hwrite), .haddr(haddr), .hwdata(hwdata), .hready(hready),
        .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
        .pb_sel(pb_sel), .pb_en(pb_en), .pb_wr(pb_wr), .pb_addr(pb_addr),
        .pb_wdata(pb_wdata), .pb_ready(pb_ready), .pb_rdata(pb_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // peripheral model
    int          wait_cfg = 0;
    int          acc_cnt = 0;
    logic [31:0] pmem [16];

    assign pb_ready = pb_en && (acc_cnt == wait_cfg);
    assign pb_rdata = pmem[pb_addr[5:2]];

    always @(posedge hclk) begin
        if (!pb_en) acc_cnt <= 0;
        else if (!pb_ready) acc_cnt <= acc_cnt + 1;
        if (pb_en && pb_ready && pb_wr) pmem[pb_addr[5:2]] <= pb_wdata;
    end

    // scoreboard
    typedef struct {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] data;
    } exp_t;
    exp_t sbq[$];

    always @(negedge hclk) begin
        if (hresetn && pb_sel && pb_en && pb_ready) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R8 unexpected peripheral transaction", pb_addr, 32'h0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(pb_addr == e.addr, "R8 peripheral address", pb_addr, e.addr);
                chk(pb_wr == e.wr, "R8 peripheral direction", {31'b0, pb_wr}, {31'b0, e.wr});
                if (e.wr) chk(pb_wdata == e.data, "R4 peripheral write data", pb_wdata, e.data);
            end
        end
    end

    // transfer list
    logic        t_wr   [16];
    logic [1:0]  t_tr   [16];
    logic [31:0] t_addr [16];
    logic [31:0] t_data [16];
    logic [31:0] exp_rd [16];
    logic [31:0] shadow [16];

    task automatic drive_addr(input int i, input int n);
        if (i < n) begin
            hsel = 1'b1; htrans = t_tr[i]; hwrite = t_wr[i]; haddr = t_addr[i];
        end else begin
            hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; haddr = '0;
        end
    endtask

    task automatic run_seq(input int n);
        int   ap = 0;
        int   dp = -1;
        int   lows = 0;
        logic rdy;
        @(posedge hclk); #1;
        drive_addr(0, n);
        while (dp >= 0 || ap < n) begin
            @(negedge hclk);
            rdy = hreadyout;
            if (rdy) begin
                if (dp >= 0) begin
                    chk(lows == wait_cfg + 2, "R7 stall length", lows, wait_cfg + 2);
                    chk(!pb_sel && !pb_en, "R6 done has peripheral idle", {30'b0, pb_sel, pb_en}, 32'h0);
                    if (!t_wr[dp]) chk(hrdata == exp_rd[dp], "R6 read data", hrdata, exp_rd[dp]);
                end
                if (ap < n) begin
                    exp_t e;
                    e.wr = t_wr[ap]; e.addr = t_addr[ap]; e.data = t_data[ap];
                    sbq.push_back(e);
                    if (t_wr[ap]) shadow[t_addr[ap][5:2]] = t_data[ap];
                    else exp_rd[ap] = shadow[t_addr[ap][5:2]];
                end
            end else begin
                if (lows == 0 && dp >= 0) begin
                    chk(pb_sel && !pb_en, "R3 setup select only", {30'b0, pb_sel, pb_en}, 32'h2);
                    chk(pb_addr == t_addr[dp], "R3 setup address", pb_addr, t_addr[dp]);
                end
                if (lows > 0) chk(pb_sel && pb_en, "R5 access select and enable", {30'b0, pb_sel, pb_en}, 32'h3);
                lows++;
            end
            @(posedge hclk); #1;
            if (rdy) begin
                dp = (ap < n) ? ap : -1;
                if (ap < n) ap++;
                lows = 0;
                drive_addr(ap, n);
                hwdata = (dp >= 0 && t_wr[dp]) ? t_data[dp] : 32'h0;
            end else begin
                hwdata = 32'hDEAD_BEEF;
            end
        end
        drive_addr(n, n);
    endtask

    task automatic ignore_case(input logic s, input logic [1:0] tr, input logic kill, input string req);
        @(posedge hclk); #1;
        hsel = s; htrans = tr; hwrite = 1'b1; haddr = 32'h10; hready_kill = kill;
        repeat (3) begin
            @(negedge hclk);
            chk(!pb_sel, req, {31'b0, pb_sel}, 32'h0);
            chk(hreadyout, req, {31'b0, hreadyout}, 32'h1);
        end
        @(posedge hclk); #1;
        hsel = 1'b0; htrans = 2'b00; hready_kill = 1'b0;
        @(negedge hclk);
        chk(!pb_sel, req, {31'b0, pb_sel}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            pmem[i] = 32'hA500_0000 | i;
            shadow[i] = 32'hA500_0000 | i;
        end
        repeat (3) @(negedge hclk);
        chk(hreadyout == 1'b1, "R1 reset ready", {31'b0, hreadyout}, 32'h1);
        chk(!pb_sel && !pb_en, "R1 reset peripheral idle", {30'b0, pb_sel, pb_en}, 32'h0);
        chk(hresp == 1'b0, "R9 reset response", {31'b0, hresp}, 32'h0);
        hresetn = 1'b1;
        @(negedge hclk);
        chk(hreadyout && !pb_sel, "R1 after reset release", {30'b0, hreadyout, pb_sel}, 32'h2);

        // R2: ignored transfers
        ignore_case(1'b1, 2'b00, 1'b0, "R2 IDLE ignored");
        ignore_case(1'b1, 2'b01, 1'b0, "R2 BUSY ignored");
        ignore_case(1'b0, 2'b10, 1'b0, "R2 unselected ignored");
        ignore_case(1'b1, 2'b10, 1'b1, "R2 hready low ignored");

        // single write then read, no wait
        wait_cfg = 0;
        t_wr[0] = 1'b1; t_tr[0] = 2'b10; t_addr[0] = 32'h0000_0014; t_data[0] = 32'h1234_5678;
        run_seq(1);
        t_wr[0] = 1'b0; t_tr[0] = 2'b10; t_addr[0] = 32'h0000_0014; t_data[0] = 32'h0;
        run_seq(1);

        // long waits
        wait_cfg = 3;
        t_wr[0] = 1'b1; t_tr[0] = 2'b10; t_addr[0] = 32'h0000_0020; t_data[0] = 32'hCAFE_F00D;
        t_wr[1] = 1'b0; t_tr[1] = 2'b10; t_addr[1] = 32'h0000_0020; t_data[1] = 32'h0;
        t_wr[2] = 1'b0; t_tr[2] = 2'b10; t_addr[2] = 32'h0000_0004; t_data[2] = 32'h0;
        run_seq(3);

        // R8: back-to-back burst, next beat presented in the done cycle
        wait_cfg = 1;
        for (int i = 0; i < 8; i++) begin
            t_wr[i]   = (i < 4);
            t_tr[i]   = (i == 0 || i == 4) ? 2'b10 : 2'b11;
            t_addr[i] = 32'h0000_0030 + 32'((i % 4) * 4);
            t_data[i] = 32'h5A00_0000 + 32'(i * 32'h111);
        end
        run_seq(8);

        repeat (4) @(negedge hclk);
        chk(sbq.size() == 0, "R8 all transactions seen", sbq.size(), 32'h0);
        chk(hresp == 1'b0, "R9 response okay", {31'b0, hresp}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge hclk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule